// File: doc/BRIEF.md
# Bank-Switched Register File

This block is the architectural register file of a small soft CPU. It presents sixteen registers, selected by a 4-bit index. The upper half of the index space (indices 8 to 15) is one fixed set of eight registers. The same storage is seen no matter which bank is active. The lower half (indices 0 to 7) is a movable window onto a deep store of 256 banks of eight registers each. In total the block holds 2056 registers at the default parameters.

The active bank is an 8-bit pointer kept in bits [15:8] of a 16-bit status register. Bits [7:0] of that register are plain storage for the rest of the core. A subroutine call steps the pointer up by one and a return steps it down by one. The caller's low registers are then preserved with no data moved to memory. Software can also load the whole status register directly, which places the pointer anywhere.

The file has two independent combinational read ports and one synchronous write port. It also has a step-up / step-down command pair, a status read/write path, and a one-cycle flag that reports when a step wraps the pointer around.

Top module: `bank_regfile`

## Requirements
- R1: Two read ports each take a 4-bit index and return the selected register combinationally, independently of each other.
- R2: Indices 0 to 7 address register idx[2:0] of the bank named by the pointer; the same index in two different banks refers to separate storage.
- R3: Indices 8 to 15 address a single fixed set of eight registers (idx[2:0]) that reads and writes identically whatever bank is active.
- R4: A write with wr_en high lands at the clock edge; a read of the same register in the write cycle returns the old value, the new value from the next cycle.
- R5: bank_up alone increments the pointer by one modulo 256 at the clock edge (255 becomes 0).
- R6: bank_down alone decrements the pointer by one modulo 256 at the clock edge (0 becomes 255).
- R7: sr_wr_en loads all 16 status bits from sr_wr_data at the clock edge (pointer in bits [15:8]), overrides any step in the same cycle, is visible on sr_rd_data, and selects the bank for reads from the next cycle.
- R8: bank_wrap is high for exactly the cycle after a step that wrapped the pointer (up from 255 or down from 0) and low otherwise.
- R9: Reset clears the status register (pointer 0) and bank_wrap but leaves register contents unchanged.
- R10: bank_up and bank_down asserted together leave the pointer unchanged and raise no wrap.
- R11: A register write issued in the same cycle as a pointer step lands in the bank that was active before the step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 16 | Read port A data |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 16 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 16 | Register write data |
| bank_up | input | 1 | Step bank pointer up |
| bank_down | input | 1 | Step bank pointer down |
| sr_wr_en | input | 1 | Status register write enable |
| sr_wr_data | input | 16 | Status register write data |
| sr_rd_data | output | 16 | Current status register |
| bank_wrap | output | 1 | Pointer wrapped on the previous step |

## Verification
The assertions check the pointer arithmetic on every cycle. This covers single steps up and down, cancellation when both commands arrive together, priority of a status load, and the wrap flag being raised only after a wrapping step. Only the bench scenarios can show what the storage holds. That includes isolation between banks, the fixed set being the same across banks, old-value reads during a write, and writes that coincide with a step reaching the old bank. The same applies to contents surviving a reset.

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int DW      = 16,
  parameter int BANK_W  = 8,
  parameter int SR_W    = 16,
  parameter int BP_LSB  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      ra_idx,
  output logic [DW-1:0]   ra_data,
  input  logic [3:0]      rb_idx,
  output logic [DW-1:0]   rb_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            bank_up,
  input  logic            bank_down,
  input  logic            sr_wr_en,
  input  logic [SR_W-1:0] sr_wr_data,
  output logic [SR_W-1:0] sr_rd_data,
  output logic            bank_wrap
);
  localparam int NBANKS = 1 << BANK_W;
  localparam int WIN    = 8;
  localparam int DEPTH  = NBANKS * WIN;
  localparam int AW     = BANK_W + 3;

  logic [DW-1:0]     win_mem [DEPTH];
  logic [DW-1:0]     fix_mem [WIN];
  logic [SR_W-1:0]   sr_q, sr_n;
  logic              wrap_n;
  logic [BANK_W-1:0] bp;

  assign bp         = sr_q[BP_LSB +: BANK_W];
  assign sr_rd_data = sr_q;

  function automatic logic [DW-1:0] rd(input logic [3:0] idx);
    logic [AW-1:0] a;
    a = {bp, idx[2:0]};
    return idx[3] ? fix_mem[idx[2:0]] : win_mem[a];
  endfunction

  assign ra_data = rd(ra_idx);
  assign rb_data = rd(rb_idx);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_idx[3]) fix_mem[wr_idx[2:0]] <= wr_data;
      else           win_mem[{bp, wr_idx[2:0]}] <= wr_data;
    end
  end

  always_comb begin
    sr_n   = sr_q;
    wrap_n = 1'b0;
    if (sr_wr_en) begin
      sr_n = sr_wr_data;
    end else if (bank_up && !bank_down) begin
      sr_n[BP_LSB +: BANK_W] = bp + 1'b1;
      wrap_n = (bp == '1);
    end else if (bank_down && !bank_up) begin
      sr_n[BP_LSB +: BANK_W] = bp - 1'b1;
      wrap_n = (bp == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= '0;
      bank_wrap <= 1'b0;
    end else begin
      sr_q      <= sr_n;
      bank_wrap <= wrap_n;
    end
  end

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr_en && bank_up && !bank_down) |=>
      sr_rd_data[BP_LSB +: BANK_W] == $past(sr_rd_data[BP_LSB +: BANK_W]) + 1'b1);

  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr_en && bank_down && !bank_up) |=>
      sr_rd_data[BP_LSB +: BANK_W] == $past(sr_rd_data[BP_LSB +: BANK_W]) - 1'b1);

  a_r7_sr_load: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_en |=> sr_rd_data == $past(sr_wr_data));

  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr_en && bank_up && bank_down) |=> $stable(sr_rd_data) && !bank_wrap);

  a_r8_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!sr_wr_en && bank_up && !bank_down && sr_rd_data[BP_LSB +: BANK_W] == '1) |=> bank_wrap);

  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_en || (bank_up == bank_down)) |=> !bank_wrap);
endmodule

// File: tb/sim_bank_regfile.sv
module sim_bank_regfile;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  ra_idx = 0, rb_idx = 0, wr_idx = 0;
  logic [15:0] ra_data, rb_data, wr_data = 0, sr_wr_data = 0, sr_rd_data;
  logic        wr_en = 0, bank_up = 0, bank_down = 0, sr_wr_en = 0, bank_wrap;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_regfile u0 (
    .clk(clk), .rst_n(rst_n), .ra_idx(ra_idx), .ra_data(ra_data),
    .rb_idx(rb_idx), .rb_data(rb_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .bank_up(bank_up), .bank_down(bank_down),
    .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
    .bank_wrap(bank_wrap)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
    wr_en = 0; bank_up = 0; bank_down = 0; sr_wr_en = 0;
    #1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [15:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step();
  endtask

  task automatic rda(input string req, input logic [3:0] i, input logic [15:0] exp);
    ra_idx = i; #1; chk(req, ra_data, exp);
  endtask

  task automatic set_sr(input logic [15:0] v);
    sr_wr_en = 1; sr_wr_data = v; step();
  endtask

  task automatic t_reset;
    chk("R9 status", sr_rd_data, 16'h0000);
    chk("R9 wrap", {15'd0, bank_wrap}, 16'h0);
  endtask

  task automatic t_banks;
    for (int i = 0; i < 8; i++) wr(4'(i), 16'h1000 + 16'(i));
    bank_up = 1; step();
    chk("R5 up", sr_rd_data, 16'h0100);
    for (int i = 0; i < 8; i++) wr(4'(i), 16'h2000 + 16'(i));
    rda("R2 bank1", 4'd5, 16'h2005);
    bank_down = 1; step();
    chk("R6 down", sr_rd_data, 16'h0000);
    rda("R2 bank0 kept", 4'd5, 16'h1005);
    rda("R2 bank0 r0", 4'd0, 16'h1000);
  endtask

  task automatic t_fixed;
    for (int i = 8; i < 16; i++) wr(4'(i), 16'h8000 + 16'(i));
    set_sr(16'h7700);
    rda("R3 fixed in bank 0x77", 4'd12, 16'h800C);
    wr(4'd9, 16'hA009);
    set_sr(16'h0000);
    rda("R3 fixed shared", 4'd9, 16'hA009);
  endtask

  task automatic t_ports;
    ra_idx = 4'd3; rb_idx = 4'd14; #1;
    chk("R1 port a", ra_data, 16'h1003);
    chk("R1 port b", rb_data, 16'h800E);
    rb_idx = 4'd3; #1;
    chk("R1 same idx both", rb_data, 16'h1003);
    wr_en = 1; wr_idx = 4'd3; wr_data = 16'h3333; #1;
    chk("R4 old value in write cycle", ra_data, 16'h1003);
    step();
    chk("R4 new value next cycle", ra_data, 16'h3333);
  endtask

  task automatic t_wrap;
    set_sr(16'hFF5A);
    bank_up = 1; step();
    chk("R5 wrap to 0", sr_rd_data, 16'h005A);
    chk("R8 wrap up flag", {15'd0, bank_wrap}, 16'h1);
    step();
    chk("R8 flag one cycle", {15'd0, bank_wrap}, 16'h0);
    bank_down = 1; step();
    chk("R6 wrap to 255", sr_rd_data, 16'hFF5A);
    chk("R8 wrap down flag", {15'd0, bank_wrap}, 16'h1);
    bank_down = 1; step();
    chk("R8 no wrap on plain step", {15'd0, bank_wrap}, 16'h0);
  endtask

  task automatic t_prio;
    set_sr(16'h0000);
    bank_up = 1; sr_wr_en = 1; sr_wr_data = 16'h01C3; step();
    chk("R7 load beats step", sr_rd_data, 16'h01C3);
    rda("R7 load selects bank", 4'd6, 16'h2006);
    bank_up = 1; bank_down = 1; step();
    chk("R10 both cancel", sr_rd_data, 16'h01C3);
    chk("R10 no wrap", {15'd0, bank_wrap}, 16'h0);
  endtask

  task automatic t_wr_step;
    wr_en = 1; wr_idx = 4'd2; wr_data = 16'hBEEF; bank_up = 1; step();
    wr(4'd2, 16'h0202);
    bank_down = 1; step();
    rda("R11 write lands in old bank", 4'd2, 16'hBEEF);
    bank_up = 1; step();
    rda("R11 new bank separate", 4'd2, 16'h0202);
  endtask

  task automatic t_reset_keep;
    rst_n = 0; step(); rst_n = 1; #1;
    chk("R9 status cleared", sr_rd_data, 16'h0000);
    rda("R9 banked kept", 4'd7, 16'h1007);
    rda("R9 fixed kept", 4'd9, 16'hA009);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1; #1;
    t_reset();
    t_banks();
    t_fixed();
    t_ports();
    t_wrap();
    t_prio();
    t_wr_step();
    t_reset_keep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule